// File: doc/BRIEF.md
# Memory-Mapped Asynchronous SRAM Bridge

This block lets a small 16-bit processor reach an external asynchronous static RAM through two locations in its data address space. The first location holds a 16-bit word address that is presented continuously on the low bits of an 18-bit SRAM address bus. The top two address bits are tied low, so the reachable window is the first 64K sixteen-bit words. The second location is the data port. A processor store to it latches the word, and on the next clock the block drives that word onto the SRAM data pins with a single-cycle active-low write strobe. A processor load from it returns whatever the SRAM is driving at that moment.

Outside a write strobe the bridge sits in a continuous read state. Output enable is low, write enable is high and the data pins are released. The bidirectional data bus is split into an output word, an input word and a drive enable, and the pad-level tristate buffer joins them. Chip select is held active for the whole run. Software does a read by storing the address and then loading the data port. It does a write by storing the address and then storing to the data port. The design assumes a 25 MHz system clock, slow enough that an SRAM read settles within one cycle.

Top module: `sram_bridge`

## Requirements
- R1: A store to location BASE_ADDR loads `bus_wdata` into the address register. From the next cycle, `sram_addr[15:0]` equals that word. `sram_addr[17:16]` is always 0.
- R2: A load from location BASE_ADDR returns the address register on `bus_rdata` in the same cycle.
- R3: A store to location BASE_ADDR+1 in cycle t captures `bus_wdata`. In cycle t+1 only, `sram_we_n`=0, `sram_oe_n`=1, `sram_dq_oe`=1 and `sram_dq_o` equals the captured word.
- R4: In every cycle that follows no data-port store, `sram_we_n`=1, `sram_oe_n`=0 and `sram_dq_oe`=0, so the data pins are released for reading.
- R5: A load from location BASE_ADDR+1 returns `sram_dq_i` on `bus_rdata` in the same cycle.
- R6: `sram_cs_n` is 0 at all times.
- R7: Data-port stores in consecutive cycles each give a strobe cycle in the cycle after, and each strobe cycle drives the word captured by its own store.
- R8: While `rst_n` is low at a clock edge, the address register, the captured word and the strobe flag clear to 0. After that edge `sram_addr`=0, `sram_dq_o`=0 and the pins are in read mode.
- R9: A store to any other location changes neither the address register nor the pin state. A load from any other location returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | BUS_AW (16) | Processor data address |
| bus_we | input | 1 | Processor store strobe |
| bus_wdata | input | DW (16) | Processor store data |
| bus_rdata | output | DW (16) | Processor load data |
| sram_addr | output | SRAM_AW (18) | SRAM word address |
| sram_dq_o | output | DW (16) | Word driven toward the SRAM data pins |
| sram_dq_i | input | DW (16) | Word sampled from the SRAM data pins |
| sram_dq_oe | output | 1 | Drive enable for the data pin tristate buffer |
| sram_cs_n | output | 1 | SRAM chip select, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |

## Verification
The main write path is tried with four patterns, and each one separates a different fault:
- A lone data-port store separates a strobe that lasts one cycle from one that sticks or comes late.
- A store followed by an idle cycle shows whether the pins return to read mode.
- Two back-to-back stores show whether the second strobe carries its own word or the stale first word.
- A store to an unmapped location shows whether the decoder leaks strobes or address updates.

Reads of both locations with changing SRAM input data separate a combinational read path from a registered one. A reset issued in the middle of the run separates a cleared state from a held one.

// File: rtl/sram_bridge_pkg.sv
// Package: sram_bridge_pkg
// Shared decode type and default sizes for the SRAM bridge.
// Assumes a word-addressed processor bus; all sizes can be overridden per instance.
package sram_bridge_pkg;

    localparam int DEF_BUS_AW  = 16;
    localparam int DEF_DW      = 16;
    localparam int DEF_SRAM_AW = 18;

    // Which register a bus address selects
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_DATA = 2'd2
    } port_sel_e;

endpackage

// File: rtl/sram_bridge_decode.sv
// Module: sram_bridge_decode
// Maps a bus address onto the address register, the data port, or nothing.
// Assumes the two registers occupy BASE_ADDR and BASE_ADDR+1.
module sram_bridge_decode
    import sram_bridge_pkg::*;
#(
    parameter int               BUS_AW    = DEF_BUS_AW,
    parameter logic [BUS_AW-1:0] BASE_ADDR = 16'h1040
) (
    input  logic [BUS_AW-1:0] bus_addr,
    output port_sel_e         sel
);

    localparam logic [BUS_AW-1:0] DATA_ADDR = BASE_ADDR + 1'b1;

    // Address comparison against both register locations
    always_comb begin
        if (bus_addr == BASE_ADDR) begin
            sel = SEL_ADDR;
        end else if (bus_addr == DATA_ADDR) begin
            sel = SEL_DATA;
        end else begin
            sel = SEL_NONE;
        end
    end

endmodule

// File: rtl/sram_bridge_addr_reg.sv
// Module: sram_bridge_addr_reg
// Holds the SRAM word address written by the processor and zero-extends it
// onto the wider SRAM address bus. Assumes SRAM_AW >= DW.
module sram_bridge_addr_reg #(
    parameter int DW      = 16,
    parameter int SRAM_AW = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DW-1:0]      wr_data,
    output logic [DW-1:0]      addr_q,
    output logic [SRAM_AW-1:0] sram_addr
);

    localparam int PAD_W = SRAM_AW - DW;

    // Address register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (wr_en) begin
            addr_q <= wr_data;
        end
    end

    // Upper SRAM address bits tied low, if there are any
    generate
        if (PAD_W > 0) begin : g_pad
            assign sram_addr = {{PAD_W{1'b0}}, addr_q};
        end else begin : g_nopad
            assign sram_addr = addr_q[SRAM_AW-1:0];
        end
    endgenerate

endmodule

// File: rtl/sram_bridge_wrseq.sv
// Module: sram_bridge_wrseq
// Captures the store word and delays the load by one flip-flop to form the
// one-cycle write strobe. Back-to-back loads give back-to-back strobes.
module sram_bridge_wrseq #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] wr_data,
    output logic          strobe,
    output logic [DW-1:0] word_q
);

    // Delayed load flag and captured write word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe <= 1'b0;
            word_q <= '0;
        end else begin
            strobe <= load;
            if (load) begin
                word_q <= wr_data;
            end
        end
    end

endmodule

// File: rtl/sram_bridge_pins.sv
// Module: sram_bridge_pins
// Turns the strobe flag into SRAM control levels and the data drive enable.
// Assumes an external tristate buffer joins dq_o/dq_i under dq_oe.
module sram_bridge_pins #(
    parameter int DW = 16
) (
    input  logic          strobe,
    input  logic [DW-1:0] word_q,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe,
    output logic          cs_n,
    output logic          oe_n,
    output logic          we_n
);

    // Read mode by default, write mode only during the strobe cycle
    always_comb begin
        cs_n  = 1'b0;
        dq_o  = word_q;
        dq_oe = strobe;
        oe_n  = strobe;
        we_n  = ~strobe;
    end

endmodule

// File: rtl/sram_bridge.sv
// Module: sram_bridge
// Top of the memory-mapped SRAM bridge: an address register at BASE_ADDR and
// a data port at BASE_ADDR+1. Reads are combinational and writes strobe one
// cycle after the store. Assumes the clock is slow enough for SRAM access.
module sram_bridge
    import sram_bridge_pkg::*;
#(
    parameter int                BUS_AW    = DEF_BUS_AW,
    parameter int                DW        = DEF_DW,
    parameter int                SRAM_AW   = DEF_SRAM_AW,
    parameter logic [BUS_AW-1:0] BASE_ADDR = 16'h1040
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic [DW-1:0]      sram_dq_o,
    input  logic [DW-1:0]      sram_dq_i,
    output logic               sram_dq_oe,
    output logic               sram_cs_n,
    output logic               sram_oe_n,
    output logic               sram_we_n
);

    port_sel_e     sel;
    logic          addr_wr;
    logic          data_load;
    logic [DW-1:0] addr_q;
    logic          strobe;
    logic [DW-1:0] word_q;

    sram_bridge_decode #(
        .BUS_AW   (BUS_AW),
        .BASE_ADDR(BASE_ADDR)
    ) decode_i (
        .bus_addr(bus_addr),
        .sel     (sel)
    );

    // Store qualification per register
    always_comb begin
        addr_wr   = bus_we && (sel == SEL_ADDR);
        data_load = bus_we && (sel == SEL_DATA);
    end

    sram_bridge_addr_reg #(
        .DW     (DW),
        .SRAM_AW(SRAM_AW)
    ) addr_reg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (addr_wr),
        .wr_data  (bus_wdata),
        .addr_q   (addr_q),
        .sram_addr(sram_addr)
    );

    sram_bridge_wrseq #(
        .DW(DW)
    ) wrseq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (data_load),
        .wr_data(bus_wdata),
        .strobe (strobe),
        .word_q (word_q)
    );

    sram_bridge_pins #(
        .DW(DW)
    ) pins_i (
        .strobe(strobe),
        .word_q(word_q),
        .dq_o  (sram_dq_o),
        .dq_oe (sram_dq_oe),
        .cs_n  (sram_cs_n),
        .oe_n  (sram_oe_n),
        .we_n  (sram_we_n)
    );

    // Processor read-data multiplexer
    always_comb begin
        unique case (sel)
            SEL_ADDR: bus_rdata = addr_q;
            SEL_DATA: bus_rdata = sram_dq_i;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sram_bridge_chk.sv
// Module: sram_bridge_chk
// Port-level protocol checks for sram_bridge, attached by bind.
module sram_bridge_chk #(
    parameter int                BUS_AW    = 16,
    parameter int                DW        = 16,
    parameter int                SRAM_AW   = 18,
    parameter logic [BUS_AW-1:0] BASE_ADDR = 16'h1040
) (
    input logic               clk,
    input logic               rst_n,
    input logic [BUS_AW-1:0]  bus_addr,
    input logic               bus_we,
    input logic [DW-1:0]      bus_wdata,
    input logic [DW-1:0]      bus_rdata,
    input logic [SRAM_AW-1:0] sram_addr,
    input logic [DW-1:0]      sram_dq_o,
    input logic [DW-1:0]      sram_dq_i,
    input logic               sram_dq_oe,
    input logic               sram_cs_n,
    input logic               sram_oe_n,
    input logic               sram_we_n
);

    localparam logic [BUS_AW-1:0] DATA_LOC = BASE_ADDR + 1'b1;

    logic st_addr;
    logic st_data;
    assign st_addr = bus_we && (bus_addr == BASE_ADDR);
    assign st_data = bus_we && (bus_addr == DATA_LOC);

    p_addr_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_addr |=> sram_addr[DW-1:0] == $past(bus_wdata));

    p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_addr |=> $stable(sram_addr));

    p_addr_top_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sram_addr[SRAM_AW-1:DW] == '0);

    p_strobe_after_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_data |=> (!sram_we_n && sram_oe_n && sram_dq_oe
                     && sram_dq_o == $past(bus_wdata)));

    p_idle_read_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !st_data |=> (sram_we_n && !sram_oe_n && !sram_dq_oe));

    p_no_contention_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (sram_oe_n && !sram_we_n));

    p_data_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == DATA_LOC) |-> bus_rdata == sram_dq_i);

    p_cs_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sram_cs_n == 1'b0);

endmodule

bind sram_bridge sram_bridge_chk #(
    .BUS_AW   (BUS_AW),
    .DW       (DW),
    .SRAM_AW  (SRAM_AW),
    .BASE_ADDR(BASE_ADDR)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sram_addr (sram_addr),
    .sram_dq_o (sram_dq_o),
    .sram_dq_i (sram_dq_i),
    .sram_dq_oe(sram_dq_oe),
    .sram_cs_n (sram_cs_n),
    .sram_oe_n (sram_oe_n),
    .sram_we_n (sram_we_n)
);

// File: tb/sram_bridge_tb_top.sv
// Bench for sram_bridge: a vector table walked by one loop, then directed
// tests for reset, read paths and unmapped accesses.
module sram_bridge_tb_top;

    localparam logic [15:0] BASE = 16'h1040;
    localparam int NV = 9;

    // Vector: {we, port(2: 0 addr, 1 data, 2 unmapped), wdata(16), exp_strobe, exp_addr(16)}
    localparam logic [35:0] VECS [NV] = '{
        {1'b1, 2'd0, 16'hA5C3, 1'b0, 16'hA5C3},
        {1'b1, 2'd1, 16'h1234, 1'b1, 16'hA5C3},
        {1'b0, 2'd1, 16'h5555, 1'b0, 16'hA5C3},
        {1'b1, 2'd1, 16'hBEEF, 1'b1, 16'hA5C3},
        {1'b1, 2'd1, 16'h0F0F, 1'b1, 16'hA5C3},
        {1'b0, 2'd0, 16'h9999, 1'b0, 16'hA5C3},
        {1'b1, 2'd2, 16'h7777, 1'b0, 16'hA5C3},
        {1'b1, 2'd0, 16'hFFFF, 1'b0, 16'hFFFF},
        {1'b0, 2'd2, 16'h0000, 1'b0, 16'hFFFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [17:0] sram_addr;
    logic [15:0] sram_dq_o;
    logic [15:0] sram_dq_i = '0;
    logic        sram_dq_oe;
    logic        sram_cs_n;
    logic        sram_oe_n;
    logic        sram_we_n;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    sram_bridge #(.BASE_ADDR(BASE)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sram_addr (sram_addr),
        .sram_dq_o (sram_dq_o),
        .sram_dq_i (sram_dq_i),
        .sram_dq_oe(sram_dq_oe),
        .sram_cs_n (sram_cs_n),
        .sram_oe_n (sram_oe_n),
        .sram_we_n (sram_we_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] port_addr(input logic [1:0] p);
        case (p)
            2'd0:    return BASE;
            2'd1:    return BASE + 16'd1;
            default: return BASE + 16'd7;
        endcase
    endfunction

    // Apply one bus cycle at the falling edge, then sample just after the rising edge
    task automatic step(input logic we, input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we    = we;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        // R8: reset with a pending data-port store held on the bus
        bus_we    = 1'b1;
        bus_addr  = BASE + 16'd1;
        bus_wdata = 16'hDEAD;
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset we_n", 32'(sram_we_n), 32'd1);
        check("R8 reset oe_n", 32'(sram_oe_n), 32'd0);
        check("R8 reset dq_oe", 32'(sram_dq_oe), 32'd0);
        check("R8 reset addr", 32'(sram_addr), 32'd0);
        check("R8 reset dq_o", 32'(sram_dq_o), 32'd0);
        check("R6 cs_n in reset", 32'(sram_cs_n), 32'd0);
        @(negedge clk);
        bus_we = 1'b0;
        rst_n  = 1'b1;

        // Vector table: R1 R3 R4 R7 R9
        for (int i = 0; i < NV; i++) begin
            logic        v_we;
            logic [1:0]  v_port;
            logic [15:0] v_data;
            logic        v_stb;
            logic [15:0] v_addr;
            {v_we, v_port, v_data, v_stb, v_addr} = VECS[i];
            step(v_we, port_addr(v_port), v_data);
            check($sformatf("R3/R4/R7 vec%0d we_n", i), 32'(sram_we_n), 32'(!v_stb));
            check($sformatf("R3/R4 vec%0d oe_n", i), 32'(sram_oe_n), 32'(v_stb));
            check($sformatf("R3/R4 vec%0d dq_oe", i), 32'(sram_dq_oe), 32'(v_stb));
            check($sformatf("R1/R9 vec%0d addr", i), 32'(sram_addr), {16'd0, v_addr});
            if (v_stb) begin
                check($sformatf("R3/R7 vec%0d dq_o", i), 32'(sram_dq_o), 32'(v_data));
            end
            check($sformatf("R6 vec%0d cs_n", i), 32'(sram_cs_n), 32'd0);
        end

        // R2: address readback, same cycle
        @(negedge clk);
        bus_we   = 1'b0;
        bus_addr = BASE;
        #1;
        check("R2 addr readback", 32'(bus_rdata), 32'h0000FFFF);

        // R5: data port returns SRAM input combinationally
        bus_addr  = BASE + 16'd1;
        sram_dq_i = 16'hC0DE;
        #1;
        check("R5 data read", 32'(bus_rdata), 32'h0000C0DE);
        sram_dq_i = 16'h3A7B;
        #1;
        check("R5 data read follows", 32'(bus_rdata), 32'h00003A7B);

        // R9: unmapped read returns 0
        bus_addr = BASE + 16'd2;
        #1;
        check("R9 unmapped read", 32'(bus_rdata), 32'd0);

        // R1: top SRAM address bits stay 0 at all-ones address
        check("R1 top bits zero", 32'(sram_addr[17:16]), 32'd0);

        // R8: mid-run reset clears address and captured word
        step(1'b1, BASE + 16'd1, 16'h4242);
        check("R3 pre-reset dq_o", 32'(sram_dq_o), 32'h00004242);
        @(negedge clk);
        bus_we = 1'b0;
        rst_n  = 1'b0;
        @(posedge clk);
        #1;
        check("R8 mid reset addr", 32'(sram_addr), 32'd0);
        check("R8 mid reset dq_o", 32'(sram_dq_o), 32'd0);
        check("R8 mid reset we_n", 32'(sram_we_n), 32'd1);
        check("R8 mid reset oe_n", 32'(sram_oe_n), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: the strobe lasts exactly one cycle
        step(1'b1, BASE + 16'd1, 16'h8001);
        check("R3 strobe on", 32'(sram_we_n), 32'd0);
        step(1'b0, BASE, 16'h0000);
        check("R3 strobe one cycle", 32'(sram_we_n), 32'd1);
        check("R4 pins released", 32'(sram_dq_oe), 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule